// File: doc/BRIEF.md
# Data-Cache Block Command Mailbox

This unit sits between software-visible special registers and a data cache. Software stores an effective address into one of five mailbox registers, one for each kind of cache block operation. The unit watches these mailboxes every cycle. When a mailbox holds a non-idle value, the unit turns it into a command for the cache, or simply discards it. Once the operation has been handed over, the unit puts the mailbox back to its idle value.

Three mailboxes lead to cache traffic:
- A prefetch becomes a word read of the stored address.
- A flush and an invalidate both become a line invalidate of the stored address.

The write-back and lock mailboxes only take in a value and then clear it. The cache takes commands over a valid/acknowledge pair. The command stays offered, and its mailbox keeps its value, until the cache acknowledges it. Software reads any mailbox back through a read port.

The reset input is asynchronous and active low. Its release must be synchronous to `clk`.

Top module: `cbo_cmd_unit`

## Requirements
- R1: After reset, the mailboxes read back as follows: prefetch (select 0) reads 0, flush (select 1) reads all-ones, invalidate (select 2) reads 0, write-back (select 3) reads 0, lock (select 4) reads 0. No command is offered after reset.
- R2: A write with select 0..4 loads the data into that mailbox at the next clock edge. From then on, `reg_rd_data` returns the mailbox contents whenever `reg_rd_sel` names it.
- R3: A nonzero prefetch mailbox offers a command with `cmd_op`=0 (read) and the mailbox address. The mailbox becomes 0 at the edge where the cache acknowledges.
- R4: A flush mailbox holding any value other than all-ones offers `cmd_op`=1 (invalidate) with that address. This includes address 0. The mailbox returns to all-ones at the acknowledging edge.
- R5: A nonzero invalidate mailbox offers `cmd_op`=1 with its address. The mailbox becomes 0 at the acknowledging edge.
- R6: A nonzero write-back or lock mailbox never causes a command. It reads 0 again one clock after it was loaded.
- R7: When several mailboxes are pending, the command is taken from the first pending one in the order prefetch, flush, invalidate. The others wait.
- R8: While `cmd_ack` is low and software does not write, the offered command keeps `cmd_valid` high and keeps its address and operation unchanged.
- R9: A software write to a pending mailbox replaces its address, and the new address is the one offered. A write that lands in the same cycle as the acknowledge wins over the clearing.
- R10: Selects 5..7 read as 0. Writes to selects 5..7 change no mailbox.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Mailbox write strobe |
| reg_wr_sel | input | 3 | Mailbox index for writes |
| reg_wr_data | input | AW | Address written to the mailbox |
| reg_rd_sel | input | 3 | Mailbox index for reads |
| reg_rd_data | output | AW | Contents of the selected mailbox |
| cmd_valid | output | 1 | A cache command is offered |
| cmd_op | output | 1 | 0 = word read (prefetch), 1 = line invalidate |
| cmd_addr | output | AW | Address of the offered command |
| cmd_ack | input | 1 | Cache accepts the offered command this cycle |

## Verification
The case that is hardest to reach is a software write that lands on a mailbox in the very cycle the cache acknowledges that same mailbox. A stale clear would then wipe out the new address. To reach it, the stimulus holds the acknowledge low while several mailboxes are filled. It then drives a write and the acknowledge together on the granted mailbox. A long stretch of random writes and acknowledges follows, with the data drawn from a small set that includes 0 and all-ones, so that collisions and both idle sentinels come up often. Outputs and read-back are compared against a behavioural model on every cycle.

// File: rtl/cbo_pkg.sv
package cbo_pkg;
  localparam int unsigned NUM_REGS      = 5;
  localparam int unsigned SEL_W         = 3;
  localparam int unsigned NUM_CACHE_OPS = 3;  // mailboxes 0..2 reach the cache

  typedef enum logic [SEL_W-1:0] {
    SEL_PREFETCH = 3'd0,
    SEL_FLUSH    = 3'd1,
    SEL_INVAL    = 3'd2,
    SEL_WRBACK   = 3'd3,
    SEL_LOCK     = 3'd4
  } mbox_sel_e;

  typedef enum logic {
    OP_READ  = 1'b0,
    OP_INVAL = 1'b1
  } cache_op_e;
endpackage

// File: rtl/cbo_mailbox.sv
module cbo_mailbox #(
  parameter int unsigned AW        = 32,
  parameter bit          IDLE_ONES = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_data,
  input  logic          svc_done,
  output logic [AW-1:0] value_q,
  output logic          pending
);
  localparam logic [AW-1:0] IDLE_VAL = {AW{IDLE_ONES}};

  logic [AW-1:0] value_d;
  logic          ld_en;

  // software write takes precedence over the service clear
  always_comb begin
    ld_en   = wr_en | svc_done;
    value_d = wr_en ? wr_data : IDLE_VAL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     value_q <= IDLE_VAL;
    else if (ld_en) value_q <= value_d;
  end

  assign pending = (value_q != IDLE_VAL);
endmodule

// File: rtl/cbo_prio_arb.sv
module cbo_prio_arb #(
  parameter int unsigned N = 3,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req,
  output logic [N-1:0]     gnt,
  output logic [IDX_W-1:0] gnt_idx,
  output logic             any_req
);
  // lowest index wins
  always_comb begin
    gnt     = '0;
    gnt_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        gnt     = '0;
        gnt[i]  = 1'b1;
        gnt_idx = IDX_W'(i);
      end
    end
    any_req = |req;
  end
endmodule

// File: rtl/cbo_cmd_unit.sv
module cbo_cmd_unit
  import cbo_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_en,
  input  logic [SEL_W-1:0] reg_wr_sel,
  input  logic [AW-1:0]    reg_wr_data,
  input  logic [SEL_W-1:0] reg_rd_sel,
  output logic [AW-1:0]    reg_rd_data,
  output logic             cmd_valid,
  output logic             cmd_op,
  output logic [AW-1:0]    cmd_addr,
  input  logic             cmd_ack
);
  localparam int unsigned IDX_W = (NUM_CACHE_OPS > 1) ? $clog2(NUM_CACHE_OPS) : 1;

  logic [AW-1:0]            reg_q [NUM_REGS];
  logic [NUM_REGS-1:0]      pend;
  logic [NUM_REGS-1:0]      wr_hit;
  logic [NUM_REGS-1:0]      svc;
  logic [NUM_CACHE_OPS-1:0] gnt;
  logic [IDX_W-1:0]         gnt_idx;
  logic                     any_req;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_mbox
    assign wr_hit[g] = reg_wr_en && (reg_wr_sel == SEL_W'(g));

    if (g < NUM_CACHE_OPS) begin : g_cache_op
      assign svc[g] = gnt[g] & cmd_ack;
    end else begin : g_drop_op
      assign svc[g] = pend[g];
    end

    cbo_mailbox #(
      .AW        (AW),
      .IDLE_ONES (g == int'(SEL_FLUSH))
    ) u_mbox (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_hit[g]),
      .wr_data  (reg_wr_data),
      .svc_done (svc[g]),
      .value_q  (reg_q[g]),
      .pending  (pend[g])
    );
  end

  cbo_prio_arb #(.N(NUM_CACHE_OPS)) u_arb (
    .req     (pend[NUM_CACHE_OPS-1:0]),
    .gnt     (gnt),
    .gnt_idx (gnt_idx),
    .any_req (any_req)
  );

  always_comb begin
    cmd_valid = any_req;
    cmd_addr  = reg_q[gnt_idx];
    cmd_op    = (gnt_idx == IDX_W'(SEL_PREFETCH)) ? OP_READ : OP_INVAL;
  end

  always_comb begin
    reg_rd_data = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (reg_rd_sel == SEL_W'(i)) reg_rd_data = reg_q[i];
    end
  end
endmodule

// File: rtl/cbo_cmd_unit_chk.sv
module cbo_cmd_unit_chk #(
  parameter int unsigned AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr_en,
  input logic [2:0]    reg_wr_sel,
  input logic          cmd_valid,
  input logic          cmd_op,
  input logic [AW-1:0] cmd_addr,
  input logic          cmd_ack,
  input logic [AW-1:0] pf_q,
  input logic [AW-1:0] fl_q,
  input logic [AW-1:0] iv_q,
  input logic [AW-1:0] wb_q,
  input logic [AW-1:0] lk_q
);
  localparam logic [AW-1:0] ONES = {AW{1'b1}};

  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ack && !reg_wr_en |=> cmd_valid && $stable(cmd_addr) && $stable(cmd_op)); // R8

  AST_PF_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    pf_q != '0 && cmd_ack && !reg_wr_en |=> pf_q == '0); // R3

  AST_FLUSH_RESTORED: assert property (@(posedge clk) disable iff (!rst_n)
    pf_q == '0 && fl_q != ONES && cmd_ack && !reg_wr_en |=> fl_q == ONES); // R4

  AST_INV_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    pf_q == '0 && fl_q == ONES && iv_q != '0 && cmd_ack && !reg_wr_en |=> iv_q == '0); // R5

  AST_WB_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    wb_q != '0 && !(reg_wr_en && reg_wr_sel == 3'd3) |=> wb_q == '0); // R6

  AST_LOCK_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    lk_q != '0 && !(reg_wr_en && reg_wr_sel == 3'd4) |=> lk_q == '0); // R6

  AST_PREFETCH_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    pf_q != '0 |-> cmd_valid && cmd_op == 1'b0 && cmd_addr == pf_q); // R7

  AST_FLUSH_BEFORE_INV: assert property (@(posedge clk) disable iff (!rst_n)
    pf_q == '0 && fl_q != ONES |-> cmd_valid && cmd_op == 1'b1 && cmd_addr == fl_q); // R7
endmodule

bind cbo_cmd_unit cbo_cmd_unit_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_wr_en  (reg_wr_en),
  .reg_wr_sel (reg_wr_sel),
  .cmd_valid  (cmd_valid),
  .cmd_op     (cmd_op),
  .cmd_addr   (cmd_addr),
  .cmd_ack    (cmd_ack),
  .pf_q       (reg_q[0]),
  .fl_q       (reg_q[1]),
  .iv_q       (reg_q[2]),
  .wb_q       (reg_q[3]),
  .lk_q       (reg_q[4])
);

// File: tb/tb_cbo_cmd_unit.sv
`timescale 1ns/1ps
module tb_cbo_cmd_unit;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          reg_wr_en;
  logic [2:0]    reg_wr_sel;
  logic [AW-1:0] reg_wr_data;
  logic [2:0]    reg_rd_sel;
  logic [AW-1:0] reg_rd_data;
  logic          cmd_valid;
  logic          cmd_op;
  logic [AW-1:0] cmd_addr;
  logic          cmd_ack;

  int checks   = 0;
  int failures = 0;
  int cycles   = 0;

  logic [AW-1:0] m [5];  // reference mailbox contents

  always #10 clk = ~clk;  // 50 MHz

  cbo_cmd_unit #(.AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
    .reg_wr_data(reg_wr_data), .reg_rd_sel(reg_rd_sel), .reg_rd_data(reg_rd_data),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_ack(cmd_ack)
  );

  function automatic logic [AW-1:0] idle_of(int i);
    return (i == 1) ? {AW{1'b1}} : '0;
  endfunction

  task automatic chk(string tag, string what, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, bit we, logic [2:0] ws, logic [AW-1:0] wd,
                      logic [2:0] rs, bit ack);
    bit ev;
    int gi;
    logic [AW-1:0] nm [5];
    @(negedge clk);
    reg_wr_en = we; reg_wr_sel = ws; reg_wr_data = wd; reg_rd_sel = rs; cmd_ack = ack;
    #1;
    ev = 1'b0; gi = 0;
    for (int i = 0; i < 3; i++)
      if (!ev && m[i] != idle_of(i)) begin ev = 1'b1; gi = i; end
    chk(tag, "cmd_valid", AW'(cmd_valid), AW'(ev));
    if (ev) begin
      chk(tag, "cmd_op", AW'(cmd_op), AW'(gi != 0));
      chk(tag, "cmd_addr", cmd_addr, m[gi]);
    end
    chk(tag, "rd_data", reg_rd_data, (rs < 5) ? m[rs] : '0);
    for (int i = 0; i < 5; i++) begin
      nm[i] = m[i];
      if (we && ws == 3'(i))                   nm[i] = wd;
      else if (i < 3 && ev && gi == i && ack)  nm[i] = idle_of(i);
      else if (i >= 3 && m[i] != '0)           nm[i] = '0;
    end
    for (int i = 0; i < 5; i++) m[i] = nm[i];
  endtask

  initial begin
    rst_n = 1'b0; reg_wr_en = 0; reg_wr_sel = 0; reg_wr_data = 0; reg_rd_sel = 0; cmd_ack = 0;
    for (int i = 0; i < 5; i++) m[i] = idle_of(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state of every mailbox
    for (int i = 0; i < 5; i++) step("R1", 0, 0, 0, 3'(i), 0);

    // R3 prefetch, held without ack (R8), then acknowledged
    step("R2", 1, 0, 32'h0000_1000, 0, 0);
    step("R8", 0, 0, 0, 0, 0);
    step("R8", 0, 0, 0, 0, 0);
    step("R3", 0, 0, 0, 0, 1);
    step("R3", 0, 0, 0, 0, 0);

    // R4 flush incl. address 0 and the all-ones idle value
    step("R4", 1, 1, 32'h0000_2040, 1, 0);
    step("R4", 0, 0, 0, 1, 1);
    step("R4", 0, 0, 0, 1, 0);
    step("R4", 1, 1, 32'h0, 1, 0);
    step("R4", 0, 0, 0, 1, 1);
    step("R4", 1, 1, 32'hFFFF_FFFF, 1, 1);
    step("R4", 0, 0, 0, 1, 1);

    // R5 invalidate
    step("R5", 1, 2, 32'h0000_3000, 2, 0);
    step("R5", 0, 0, 0, 2, 1);
    step("R5", 0, 0, 0, 2, 0);

    // R6 write-back and lock self-clear, no command
    step("R6", 1, 3, 32'h0000_0044, 3, 1);
    step("R6", 1, 4, 32'h0000_0055, 3, 1);
    step("R6", 0, 0, 0, 4, 1);
    step("R6", 0, 0, 0, 4, 1);

    // R7 priority among three pending mailboxes
    step("R7", 1, 2, 32'hA000_0002, 0, 0);
    step("R7", 1, 1, 32'hA000_0001, 0, 0);
    step("R7", 1, 0, 32'hA000_0000, 0, 0);
    step("R7", 0, 0, 0, 1, 1);
    step("R7", 0, 0, 0, 2, 1);
    step("R7", 0, 0, 0, 0, 1);
    step("R7", 0, 0, 0, 0, 0);

    // R9 overwrite while pending, and write colliding with ack
    step("R9", 1, 0, 32'hB000_0000, 0, 0);
    step("R9", 1, 0, 32'hB000_0004, 0, 0);
    step("R9", 1, 0, 32'hB000_0008, 0, 1);
    step("R9", 0, 0, 0, 0, 0);
    step("R9", 0, 0, 0, 0, 1);
    step("R9", 0, 0, 0, 0, 0);

    // R10 unused selects
    step("R10", 1, 5, 32'hDEAD_BEEF, 5, 0);
    step("R10", 1, 7, 32'h1234_5678, 6, 0);
    step("R10", 0, 0, 0, 7, 0);
    for (int i = 0; i < 5; i++) step("R10", 0, 0, 0, 3'(i), 0);

    // R2 random mix
    for (int n = 0; n < 2000; n++) begin
      logic [AW-1:0] d;
      case ($urandom_range(0, 3))
        0: d = '0;
        1: d = {AW{1'b1}};
        default: d = AW'($urandom);
      endcase
      step("R2", ($urandom_range(0, 2) == 0), 3'($urandom_range(0, 7)), d,
           3'($urandom_range(0, 7)), ($urandom_range(0, 1) == 1));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog (all requirements): actual=%0d cycles expected=completion", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule